// File: doc/BRIEF.md
# Single-Wire Thermometer Slave Command Engine

This block is the byte-level protocol layer of a temperature sensor that sits on a single-wire open-drain bus. A bit-level front end (outside this block) turns bus time slots into received bytes, read-slot requests and bus-reset events. This block returns the bytes to send back. It tracks each transaction through three stages: a bus reset, then one device-addressing command, then one function command. It keeps a nine-byte scratchpad in which two alarm-limit bytes have non-volatile shadow copies. It also runs timed conversion, copy and recall operations and raises a busy output while any of them runs.

The temperature is taken from a port when a conversion ends. The checksum byte at the end of the scratchpad comes from a neighbouring block. A conversion updates an alarm flag by comparing the temperature against the two limits. The two search commands are recognised but need bit-level arbitration, which is not part of this block, so the engine stays silent after either of them until the next bus reset. A conversion, copy or recall command sent while an earlier one is still busy is not started.

Top module: `thermo_cmd_slave`

## Requirements
- R1: Function commands are acted on only after a bus reset followed by an accepted addressing command (33h, 55h or CCh). Bytes received before the first bus reset are ignored. An unknown addressing code, the search code F0h and the alarm-search code ECh all make the block ignore received bytes until the next bus reset. While the block ignores the bus, every read slot returns FFh.
- R2: Addressing code 33h makes the next eight read slots return the 64-bit identity, lowest byte first: family byte 10h, then the 48-bit serial (parameter) lowest byte first, then the identity checksum byte (parameter). Any further read slot returns FFh.
- R3: Addressing code 55h is followed by eight identity bytes, lowest byte first. If all eight match, the block accepts a function command. On the first mismatch the block ignores the bus until the next bus reset.
- R4: Addressing code CCh skips the identity and accepts a function command straight away.
- R5: Function code BEh makes read slots return the scratchpad in byte order: 0 = temperature low byte, 1 = temperature high byte, 2 = upper limit, 3 = lower limit, 4 and 5 = FFh, 6 = remaining count, 7 = fixed 10h, 8 = checksum input. Any read after byte 8 returns FFh. After power-up, bytes 0, 1 and 6 hold AAh, 00h and 0Ch.
- R6: Function code 4Eh takes two bytes: the upper limit first, then the lower limit. Both are written together when the second byte arrives. A bus reset after only the first byte leaves both limits unchanged.
- R7: Function code 44h holds busy high for exactly CONV_CYCLES cycles, starting in the cycle after the command byte. When busy falls, the temperature bytes load from temp_in (a 16-bit sign-extended two's-complement value in 0.5 °C steps) and byte 6 loads from cremain_in.
- R8: When a conversion ends, the alarm output is set if temp_in bits 8..1, read as a signed byte, are greater than the upper limit or less than the lower limit. Otherwise it is cleared. The alarm does not change at any other time.
- R9: Function code 48h copies both limits into the shadow copy, with busy high for COPY_CYCLES cycles. Function code B8h reloads both limits from the shadow copy, with busy high for RECALL_CYCLES cycles. After power-up the limits equal the shadow's initial values.
- R10: After a 44h, 48h or B8h command, each read slot returns 00h while busy is high and FFh once it is low.
- R11: Every read-slot request is answered by tx_valid, with its byte, exactly one cycle later. tx_valid is never raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_reset | input | 1 | One-cycle pulse: bus reset seen by the front end |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Front end asks for the next byte to send |
| temp_in | input | 16 | Sensor temperature, sign-extended, 0.5 °C steps |
| cremain_in | input | 8 | Remaining-count value stored by a conversion |
| crc_in | input | 8 | Scratchpad checksum from the neighbouring block |
| tx_valid | output | 1 | tx_byte is valid |
| tx_byte | output | 8 | Byte to send |
| busy | output | 1 | A conversion, copy or recall is running |
| alarm | output | 1 | Alarm flag from the last conversion |

## Verification
The bench sweeps temperatures across the full 9-bit range against several limit pairs, including equal and negative limits. A design that compared the wrong bits, or compared them unsigned, would raise the alarm on the wrong side of zero or at the boundary values. It writes only one limit byte and then resets, to catch a design that commits each byte as it arrives. It sends a wrong identity byte in the middle of a match, to catch a design that keeps listening after a mismatch. It counts busy cycles for conversion, copy and recall, so an off-by-one in the timer shows up. It reads past the last byte of both the identity and the scratchpad, so a design whose index wraps around would return stale data there instead of FFh.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    typedef enum logic [3:0] {
        ST_MUTE,
        ST_ROM,
        ST_MATCH,
        ST_ID_RD,
        ST_FUNC,
        ST_WR_HI,
        ST_WR_LO,
        ST_SPAD_RD,
        ST_STATUS
    } st_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CONV,
        OP_COPY,
        OP_RECALL
    } op_e;

    localparam logic [7:0] A_SEARCH  = 8'hF0;
    localparam logic [7:0] A_READ_ID = 8'h33;
    localparam logic [7:0] A_MATCH   = 8'h55;
    localparam logic [7:0] A_SKIP    = 8'hCC;
    localparam logic [7:0] A_ALSRCH  = 8'hEC;

    localparam logic [7:0] F_CONV    = 8'h44;
    localparam logic [7:0] F_WRITE   = 8'h4E;
    localparam logic [7:0] F_READ    = 8'hBE;
    localparam logic [7:0] F_COPY    = 8'h48;
    localparam logic [7:0] F_RECALL  = 8'hB8;

    typedef struct packed {
        st_e         st;
        logic [3:0]  idx;
        logic [7:0]  th;
        logic [7:0]  tl;
        logic [7:0]  nv_th;
        logic [7:0]  nv_tl;
        logic [7:0]  pend;
        logic [15:0] temp;
        logic [7:0]  crem;
        logic        alarm;
        logic        tx_valid;
        logic [7:0]  tx_byte;
    } regs_t;

endpackage

// File: rtl/thermo_op_timer.sv
module thermo_op_timer
    import thermo_pkg::*;
#(
    parameter int CONV_CYCLES   = 750,
    parameter int COPY_CYCLES   = 100,
    parameter int RECALL_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  start_kind,
    output logic busy,
    output logic done,
    output op_e  kind
);
    localparam int MAXL = (CONV_CYCLES > COPY_CYCLES)
                        ? ((CONV_CYCLES > RECALL_CYCLES) ? CONV_CYCLES : RECALL_CYCLES)
                        : ((COPY_CYCLES > RECALL_CYCLES) ? COPY_CYCLES : RECALL_CYCLES);
    localparam int CW = $clog2(MAXL + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        op_e           kind;
    } tim_t;

    tim_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (q.busy) begin
            if (q.cnt == '0) begin
                done   = 1'b1;
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.kind = start_kind;
            case (start_kind)
                OP_CONV: d.cnt = CW'(CONV_CYCLES - 1);
                OP_COPY: d.cnt = CW'(COPY_CYCLES - 1);
                default: d.cnt = CW'(RECALL_CYCLES - 1);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, cnt: '0, kind: OP_NONE};
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign kind = q.kind;
endmodule

// File: rtl/thermo_alarm_cmp.sv
module thermo_alarm_cmp (
    input  logic [7:0] coarse,
    input  logic [7:0] hi_lim,
    input  logic [7:0] lo_lim,
    output logic       hit
);
    always_comb begin
        hit = ($signed(coarse) > $signed(hi_lim)) || ($signed(coarse) < $signed(lo_lim));
    end
endmodule

// File: rtl/thermo_spad_sel.sv
module thermo_spad_sel #(
    parameter logic [7:0] COUNT_PER = 8'h10
) (
    input  logic [3:0]  sel,
    input  logic [15:0] temp,
    input  logic [7:0]  th,
    input  logic [7:0]  tl,
    input  logic [7:0]  crem,
    input  logic [7:0]  crc,
    output logic [7:0]  data
);
    always_comb begin
        case (sel)
            4'd0:    data = temp[7:0];
            4'd1:    data = temp[15:8];
            4'd2:    data = th;
            4'd3:    data = tl;
            4'd6:    data = crem;
            4'd7:    data = COUNT_PER;
            4'd8:    data = crc;
            default: data = 8'hFF;
        endcase
    end
endmodule

// File: rtl/thermo_cmd_slave.sv
module thermo_cmd_slave
    import thermo_pkg::*;
#(
    parameter logic [47:0] SERIAL        = 48'h0000_1234_5678,
    parameter logic [7:0]  ID_CRC        = 8'hA5,
    parameter logic [7:0]  NV_TH_INIT    = 8'h4B,
    parameter logic [7:0]  NV_TL_INIT    = 8'h46,
    parameter int          CONV_CYCLES   = 750,
    parameter int          COPY_CYCLES   = 100,
    parameter int          RECALL_CYCLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_reset,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_req,
    input  logic [15:0] temp_in,
    input  logic [7:0]  cremain_in,
    input  logic [7:0]  crc_in,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        busy,
    output logic        alarm
);
    localparam logic [7:0]  FAMILY   = 8'h10;
    localparam logic [63:0] IDENT    = {ID_CRC, SERIAL, FAMILY};
    localparam int          ID_BYTES = 8;
    localparam int          SP_BYTES = 9;

    regs_t q, d;

    logic       op_start, op_done, alarm_hit;
    op_e        op_req, op_kind;
    logic [7:0] spad_byte, id_byte;

    thermo_op_timer #(
        .CONV_CYCLES(CONV_CYCLES), .COPY_CYCLES(COPY_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(op_start), .start_kind(op_req),
        .busy(busy), .done(op_done), .kind(op_kind)
    );

    thermo_alarm_cmp u_cmp (
        .coarse(temp_in[8:1]), .hi_lim(q.th), .lo_lim(q.tl), .hit(alarm_hit)
    );

    thermo_spad_sel #(.COUNT_PER(8'h10)) u_sel (
        .sel(q.idx), .temp(q.temp), .th(q.th), .tl(q.tl),
        .crem(q.crem), .crc(crc_in), .data(spad_byte)
    );

    assign id_byte = IDENT[q.idx[2:0]*8 +: 8];

    always_comb begin
        d          = q;
        d.tx_valid = 1'b0;
        op_start   = 1'b0;
        op_req     = OP_NONE;

        // read slots answered from the state held before this edge
        if (tx_req) begin
            d.tx_valid = 1'b1;
            d.tx_byte  = 8'hFF;
            case (q.st)
                ST_ID_RD: begin
                    if (q.idx < 4'(ID_BYTES)) begin
                        d.tx_byte = id_byte;
                        d.idx     = q.idx + 1'b1;
                    end
                end
                ST_SPAD_RD: begin
                    if (q.idx < 4'(SP_BYTES)) begin
                        d.tx_byte = spad_byte;
                        d.idx     = q.idx + 1'b1;
                    end
                end
                ST_STATUS: d.tx_byte = busy ? 8'h00 : 8'hFF;
                default:   d.tx_byte = 8'hFF;
            endcase
        end

        if (bus_reset) begin
            d.st  = ST_ROM;
            d.idx = '0;
        end else if (rx_valid) begin
            case (q.st)
                ST_ROM: begin
                    d.idx = '0;
                    case (rx_byte)
                        A_READ_ID: d.st = ST_ID_RD;
                        A_MATCH:   d.st = ST_MATCH;
                        A_SKIP:    d.st = ST_FUNC;
                        A_SEARCH,
                        A_ALSRCH:  d.st = ST_MUTE;
                        default:   d.st = ST_MUTE;
                    endcase
                end
                ST_MATCH: begin
                    if (rx_byte != id_byte) begin
                        d.st = ST_MUTE;
                    end else if (q.idx == 4'(ID_BYTES - 1)) begin
                        d.st = ST_FUNC;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_FUNC: begin
                    d.idx = '0;
                    case (rx_byte)
                        F_CONV: begin
                            d.st = ST_STATUS; op_start = !busy; op_req = OP_CONV;
                        end
                        F_COPY: begin
                            d.st = ST_STATUS; op_start = !busy; op_req = OP_COPY;
                        end
                        F_RECALL: begin
                            d.st = ST_STATUS; op_start = !busy; op_req = OP_RECALL;
                        end
                        F_WRITE: d.st = ST_WR_HI;
                        F_READ:  d.st = ST_SPAD_RD;
                        default: d.st = ST_MUTE;
                    endcase
                end
                ST_WR_HI: begin
                    d.pend = rx_byte;
                    d.st   = ST_WR_LO;
                end
                ST_WR_LO: begin
                    d.th = q.pend;
                    d.tl = rx_byte;
                    d.st = ST_MUTE;
                end
                default: ;
            endcase
        end

        if (op_done) begin
            case (op_kind)
                OP_CONV: begin
                    d.temp  = temp_in;
                    d.crem  = cremain_in;
                    d.alarm = alarm_hit;
                end
                OP_COPY: begin
                    d.nv_th = q.th;
                    d.nv_tl = q.tl;
                end
                OP_RECALL: begin
                    d.th = q.nv_th;
                    d.tl = q.nv_tl;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_MUTE, idx: '0, th: NV_TH_INIT, tl: NV_TL_INIT,
                   nv_th: NV_TH_INIT, nv_tl: NV_TL_INIT, pend: '0,
                   temp: 16'h00AA, crem: 8'h0C, alarm: 1'b0,
                   tx_valid: 1'b0, tx_byte: 8'hFF};
        end else begin
            q <= d;
        end
    end

    assign tx_valid = q.tx_valid;
    assign tx_byte  = q.tx_byte;
    assign alarm    = q.alarm;
endmodule

// File: rtl/thermo_cmd_slave_chk.sv
module thermo_cmd_slave_chk #(
    parameter int CONV_CYCLES   = 750,
    parameter int COPY_CYCLES   = 100,
    parameter int RECALL_CYCLES = 20
) (
    input logic clk,
    input logic rst_n,
    input logic tx_req,
    input logic tx_valid,
    input logic busy,
    input logic alarm
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= busy ? run_q + 1 : '0;
    end

    AST_TX_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);                                        // R11
    AST_TX_UNSOLICITED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);                                      // R11
    AST_ALARM_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alarm) |-> $fell(busy));                            // R8
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(CONV_CYCLES) || run_q == 32'(COPY_CYCLES)
                         || run_q == 32'(RECALL_CYCLES)));           // R7
endmodule

bind thermo_cmd_slave thermo_cmd_slave_chk #(
    .CONV_CYCLES(CONV_CYCLES), .COPY_CYCLES(COPY_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_valid(tx_valid),
    .busy(busy), .alarm(alarm)
);

// File: tb/thermo_cmd_slave_test.sv
module thermo_cmd_slave_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [47:0] SER   = 48'hA1B2_C3D4_E5F6;
    localparam logic [7:0]  IDCRC = 8'h5D;
    localparam logic [7:0]  TH0   = 8'h46;
    localparam logic [7:0]  TL0   = 8'hF6;
    localparam int          CONV  = 12;
    localparam int          COPY  = 6;
    localparam int          RECL  = 5;
    localparam logic [7:0]  CRCV  = 8'h3C;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_reset = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0]  rx_byte = '0, cremain_in = '0;
    logic [15:0] temp_in = '0;
    logic        tx_valid, busy, alarm;
    logic [7:0]  tx_byte;

    int checks = 0, failures = 0;
    logic [7:0] sp [0:9];

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_cmd_slave #(
        .SERIAL(SER), .ID_CRC(IDCRC), .NV_TH_INIT(TH0), .NV_TL_INIT(TL0),
        .CONV_CYCLES(CONV), .COPY_CYCLES(COPY), .RECALL_CYCLES(RECL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .temp_in(temp_in),
        .cremain_in(cremain_in), .crc_in(CRCV), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .busy(busy), .alarm(alarm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] id_at(input int i);
        if (i == 0) return 8'h10;
        if (i == 7) return IDCRC;
        return SER[(i-1)*8 +: 8];
    endfunction

    task automatic do_reset();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b);
        @(negedge clk) tx_req = 1'b1;
        @(negedge clk) tx_req = 1'b0;
        b = tx_byte;
        checks++;
        if (tx_valid !== 1'b1) begin
            failures++;
            $display("FAIL R11 actual=%0b expected=1", tx_valid);
        end
    endtask

    task automatic start_fn(input logic [7:0] c);
        do_reset(); send(8'hCC); send(c);
    endtask

    task automatic read_spad();
        start_fn(8'hBE);
        for (int i = 0; i < 10; i++) recv(sp[i]);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic set_limits(input logic [7:0] h, input logic [7:0] l);
        start_fn(8'h4E); send(h); send(l);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset busy", busy, 0);
        check("reset alarm", alarm, 0);
        check("reset tx_valid", tx_valid, 0);

        // R1: bytes before any bus reset are ignored
        send(8'hCC); send(8'h4E); send(8'h11); send(8'h22);
        read_spad();
        check("R1 pre-reset write ignored th", sp[2], TH0);
        check("R1 pre-reset write ignored tl", sp[3], TL0);
        // R5 and R9: power-up map
        check("R5 byte0", sp[0], 8'hAA);
        check("R5 byte1", sp[1], 8'h00);
        check("R5 byte4", sp[4], 8'hFF);
        check("R5 byte5", sp[5], 8'hFF);
        check("R5 byte6", sp[6], 8'h0C);
        check("R5 byte7", sp[7], 8'h10);
        check("R5 byte8", sp[8], CRCV);
        check("R5 past end", sp[9], 8'hFF);

        // R1: function code given as addressing code mutes
        do_reset(); send(8'hBE); recv(b);
        check("R1 muted read", b, 8'hFF);
        // R1: search codes mute
        do_reset(); send(8'hEC); send(8'h4E); send(8'h01); send(8'h02);
        do_reset(); send(8'hF0); send(8'h4E); send(8'h01); send(8'h02);
        read_spad();
        check("R1 after search th", sp[2], TH0);

        // R2: identity read
        do_reset(); send(8'h33);
        for (int i = 0; i < 8; i++) begin
            recv(b); check($sformatf("R2 id byte %0d", i), b, id_at(i));
        end
        recv(b); check("R2 past end", b, 8'hFF);

        // R3: good match then write
        do_reset(); send(8'h55);
        for (int i = 0; i < 8; i++) send(id_at(i));
        send(8'h4E); send(8'h21); send(8'hE3);
        read_spad();
        check("R3 match write th", sp[2], 8'h21);
        check("R6 order tl", sp[3], 8'hE3);
        // R3: mismatch in byte 3
        do_reset(); send(8'h55);
        for (int i = 0; i < 8; i++) send(i == 3 ? id_at(i) ^ 8'h08 : id_at(i));
        send(8'h4E); send(8'h01); send(8'h02);
        read_spad();
        check("R3 mismatch ignored th", sp[2], 8'h21);
        check("R4 skip read tl", sp[3], 8'hE3);

        // R6: reset after one byte
        start_fn(8'h4E); send(8'h77);
        read_spad();
        check("R6 partial th", sp[2], 8'h21);
        check("R6 partial tl", sp[3], 8'hE3);

        // R9 / R10: copy, overwrite, recall
        set_limits(8'h12, 8'h34);
        start_fn(8'h48); recv(b);
        check("R10 copy busy status", b, 8'h00);
        wait_idle(n);
        check("R9 copy length", n, COPY - 2);
        recv(b); check("R10 copy done status", b, 8'hFF);
        set_limits(8'h56, 8'h78);
        start_fn(8'hB8);
        recv(b); check("R10 recall busy status", b, 8'h00);
        wait_idle(n);
        check("R9 recall length", n, RECL - 2);
        recv(b); check("R10 recall done status", b, 8'hFF);
        read_spad();
        check("R9 recalled th", sp[2], 8'h12);
        check("R9 recalled tl", sp[3], 8'h34);

        // R7: conversion loads temperature and count
        temp_in = 16'hFFCE; cremain_in = 8'h07;
        start_fn(8'h44);
        wait_idle(n);
        check("R7 conv length", n, CONV);
        read_spad();
        check("R7 temp lsb", sp[0], 8'hCE);
        check("R7 temp msb", sp[1], 8'hFF);
        check("R7 count remain", sp[6], 8'h07);

        // R8: sweep temperatures against limit pairs
        for (int p = 0; p < 3; p++) begin
            logic signed [7:0] h, l;
            h = (p == 0) ? 8'sd25 : (p == 1) ? 8'sd0 : -8'sd20;
            l = (p == 0) ? -8'sd10 : (p == 1) ? 8'sd0 : -8'sd60;
            set_limits(h, l);
            for (int t = -255; t <= 255; t += 11) begin
                logic signed [15:0] tv;
                logic signed [7:0]  c;
                tv = 16'(t);
                c  = tv[8:1];
                temp_in = tv;
                cremain_in = 8'(t);
                start_fn(8'h44);
                wait_idle(n);
                check($sformatf("R8 t=%0d h=%0d l=%0d", t, h, l), alarm,
                      {31'd0, (c > h) || (c < l)});
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule